// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a clocked subsystem use an external asynchronous static RAM of 128K words by 16 bits. The RAM is controlled by active-low chip select, output gate, write strobe and one strobe per byte lane. The controller takes one request at a time on a valid/ready handshake: a word address, a write flag, 16 bits of write data and a two-bit lane mask (bit 0 = bits 7:0, bit 1 = bits 15:8). It drives the RAM's address and control pins and the shared data bus. The bus is split into an outgoing value, a per-lane drive enable and an incoming sample. Read results come back on a response port with a one-cycle valid pulse.

Every interval the RAM needs is held for a whole number of clock cycles. The count is the RAM's nanosecond figure for the chosen speed grade (55, 70 or 100 ns), divided by the clock period and rounded up. Writes are ended by the write strobe. Only the lanes named in the mask are strobed and driven. When no access is in flight the RAM is left deselected, in its low-power standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in flight, `req_ready` is 1, chip select, output gate and write strobe are all high (inactive), no lane is driven and `rsp_valid` is 0.
- R2: A read holds chip select and output gate low with the write strobe high. It samples the bus RD = ceil(tAA / CLK_NS) cycles after acceptance and presents the word on `rsp_data` with `rsp_valid` high for exactly one cycle, RD cycles after the accepting edge.
- R3: On a read, a lane whose mask bit is 0 keeps its strobe high (lane 0 on `ram_lb_n`, lane 1 on `ram_ub_n`), and its bits of `rsp_data` are returned as zero.
- R4: A write with a nonzero mask holds the output gate high and pulls the write strobe low for exactly WL cycles, where WL = max(ceil(tPWE), ceil(tAW), ceil(tHZWE) + ceil(tSD)). Only masked lanes are strobed and driven, and only those lanes change in the RAM.
- R5: The controller drives a lane only while the output gate is high. Driving starts at least tHZWE after the write strobe falls and at least tHZOE after the output gate rises, and lasts at least tSD before the strobe rises. It stops exactly one cycle after the write strobe rises.
- R6: After the read sample, the controller waits ceil(tHZOE / CLK_NS) further cycles before it is ready again, so a read keeps `req_ready` low for RD + ceil(tHZOE) cycles.
- R7: A write keeps `req_ready` low for max(WL + 1, ceil(tWC / CLK_NS)) cycles.
- R8: A write with mask 00 is accepted in one cycle and leaves no trace: the write strobe never falls, chip select stays high, `req_ready` is 1 in the next cycle and the RAM contents are unchanged.
- R9: While chip select is low, the address and lane strobes stay constant.
- R10: The speed grade sets tAA/tDOE/tHZOE/tPWE/tAW/tSD/tHZWE/tWC to 55/30/20/45/50/25/30/55 ns, 70/35/25/60/65/30/30/70 ns or 100/50/30/80/80/40/40/100 ns; any other value selects the slowest set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output gate, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_ub_n | output | 1 | RAM high-byte strobe, active low |
| ram_lb_n | output | 1 | RAM low-byte strobe, active low |
| ram_dq_out | output | 16 | Value the controller drives on the data bus |
| ram_dq_oe | output | 2 | Per-lane drive enable for the data bus |
| ram_dq_in | input | 16 | Value sampled from the data bus |

## Verification
The assertions watch the pin rules that must hold in every cycle. They check that the RAM is left in standby while idle and that the output gate stays high under a write strobe. They also check that the controller never drives while the output gate is low, that driving stops one cycle after the strobe rises, that the address and strobes are stable while selected, and that a response is a single pulse. Other behaviour depends on exact cycle counts and on memory contents, so only the bench scenarios can show it. That covers the read latency, the strobe width, the data setup time, the busy lengths of reads and writes, lane-selective merging into stored words, zeroed unselected read lanes, and the mask-00 write that leaves memory untouched.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_WHOLD,
    ST_RECOVER
  } ctl_state_t;

  typedef enum int unsigned {
    TK_ACCESS, TK_OE_ACC, TK_OE_FLOAT, TK_WE_PULSE,
    TK_ADDR_END, TK_DATA_SETUP, TK_WE_FLOAT, TK_CYCLE
  } tkind_t;

  // Nanosecond figure for one interval of one speed grade.
  function automatic int unsigned grade_ns(int unsigned grade, tkind_t k);
    int unsigned v;
    case (grade)
      55: case (k)
            TK_ACCESS: v = 55;  TK_OE_ACC: v = 30;  TK_OE_FLOAT: v = 20;
            TK_WE_PULSE: v = 45; TK_ADDR_END: v = 50; TK_DATA_SETUP: v = 25;
            TK_WE_FLOAT: v = 30; default: v = 55;
          endcase
      70: case (k)
            TK_ACCESS: v = 70;  TK_OE_ACC: v = 35;  TK_OE_FLOAT: v = 25;
            TK_WE_PULSE: v = 60; TK_ADDR_END: v = 65; TK_DATA_SETUP: v = 30;
            TK_WE_FLOAT: v = 30; default: v = 70;
          endcase
      default: case (k)
            TK_ACCESS: v = 100; TK_OE_ACC: v = 50;  TK_OE_FLOAT: v = 30;
            TK_WE_PULSE: v = 80; TK_ADDR_END: v = 80; TK_DATA_SETUP: v = 40;
            TK_WE_FLOAT: v = 40; default: v = 100;
          endcase
    endcase
    return v;
  endfunction

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Whole cycles covering one interval, never less than one.
  function automatic int unsigned span(int unsigned grade, tkind_t k, int unsigned clk_ns);
    return umax(1, ceil_div(grade_ns(grade, k), clk_ns));
  endfunction

  function automatic int unsigned read_cycles(int unsigned grade, int unsigned clk_ns);
    return umax(span(grade, TK_ACCESS, clk_ns), span(grade, TK_OE_ACC, clk_ns));
  endfunction

  function automatic int unsigned strobe_cycles(int unsigned grade, int unsigned clk_ns);
    return umax(umax(span(grade, TK_WE_PULSE, clk_ns), span(grade, TK_ADDR_END, clk_ns)),
                span(grade, TK_WE_FLOAT, clk_ns) + span(grade, TK_DATA_SETUP, clk_ns));
  endfunction

  function automatic int unsigned write_tail(int unsigned grade, int unsigned clk_ns);
    int unsigned used;
    used = strobe_cycles(grade, clk_ns) + 1;
    return (span(grade, TK_CYCLE, clk_ns) > used) ? span(grade, TK_CYCLE, clk_ns) - used : 0;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
`timescale 1ns/1ps
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned WL_CYC   = 6,
  parameter int unsigned FLT_CYC  = 3,
  parameter int unsigned HZOE_CYC = 2,
  parameter int unsigned TAIL_CYC = 0,
  parameter int unsigned CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  output logic             req_ready,
  output logic             ev_accept_rd,
  output logic             ev_accept_wr,
  output logic             ev_noop,
  output logic             ev_capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] lane_act,
  output logic             drive_en,
  output logic             rsp_valid
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WL_LOAD   = CNT_W'(WL_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_MARK  = CNT_W'(WL_CYC - FLT_CYC);
  localparam logic [CNT_W-1:0] HZOE_LOAD = CNT_W'(HZOE_CYC - 1);
  localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'((TAIL_CYC > 0) ? TAIL_CYC - 1 : 0);

  ctl_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             cnt_done;

  assign req_ready    = (state == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign ev_accept_rd = accept && !req_write;
  assign ev_accept_wr = accept && req_write && (|req_mask);
  assign ev_noop      = accept && req_write && !(|req_mask);
  assign cnt_done     = (cnt == '0);
  assign ev_capture   = (state == ST_READ) && cnt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      lane_act  <= '0;
      drive_en  <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ev_accept_rd) begin
            state    <= ST_READ;
            cnt      <= RD_LOAD;
            ce_n     <= 1'b0;
            oe_n     <= 1'b0;
            lane_act <= req_mask;
          end else if (ev_accept_wr) begin
            state    <= ST_WRITE;
            cnt      <= WL_LOAD;
            ce_n     <= 1'b0;
            we_n     <= 1'b0;
            lane_act <= req_mask;
          end
        end
        ST_READ: begin
          if (cnt_done) begin
            rsp_valid <= 1'b1;
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            lane_act  <= '0;
            state     <= ST_RECOVER;
            cnt       <= HZOE_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WRITE: begin
          if (cnt_done) begin
            we_n  <= 1'b1;
            state <= ST_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
            if (cnt == DRV_MARK) drive_en <= 1'b1;
          end
        end
        ST_WHOLD: begin
          drive_en <= 1'b0;
          ce_n     <= 1'b1;
          lane_act <= '0;
          if (TAIL_CYC > 0) begin
            state <= ST_RECOVER;
            cnt   <= TAIL_LOAD;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_RECOVER: begin
          if (cnt_done) state <= ST_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_datapath.sv
`timescale 1ns/1ps
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              drive_en,
  input  logic [LANES-1:0]  lane_act,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic [LANES-1:0]  ram_dq_oe,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
    end else if (load) begin
      ram_addr   <= req_addr;
      ram_dq_out <= req_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign ram_dq_oe[g] = drive_en && lane_act[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsp_data[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rsp_data[g*LANE_W +: LANE_W] <= lane_act[g] ? ram_dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned CLK_NS   = 10,
  parameter int unsigned SPEED_NS = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              ram_ub_n,
  output logic              ram_lb_n,
  output logic [15:0]       ram_dq_out,
  output logic [1:0]        ram_dq_oe,
  input  logic [15:0]       ram_dq_in
);

  localparam int unsigned RD_CYC   = read_cycles(SPEED_NS, CLK_NS);
  localparam int unsigned WL_CYC   = strobe_cycles(SPEED_NS, CLK_NS);
  localparam int unsigned FLT_CYC  = span(SPEED_NS, TK_WE_FLOAT, CLK_NS);
  localparam int unsigned HZOE_CYC = span(SPEED_NS, TK_OE_FLOAT, CLK_NS);
  localparam int unsigned TAIL_CYC = write_tail(SPEED_NS, CLK_NS);
  localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WL_CYC), umax(HZOE_CYC, TAIL_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             ev_accept_rd;
  logic             ev_accept_wr;
  logic             ev_noop;
  logic             ev_capture;
  logic             drive_en;
  logic [LANES-1:0] lane_act;

  sram_lane_fsm #(
    .RD_CYC  (RD_CYC),
    .WL_CYC  (WL_CYC),
    .FLT_CYC (FLT_CYC),
    .HZOE_CYC(HZOE_CYC),
    .TAIL_CYC(TAIL_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_mask    (req_mask),
    .req_ready   (req_ready),
    .ev_accept_rd(ev_accept_rd),
    .ev_accept_wr(ev_accept_wr),
    .ev_noop     (ev_noop),
    .ev_capture  (ev_capture),
    .ce_n        (ram_ce_n),
    .oe_n        (ram_oe_n),
    .we_n        (ram_we_n),
    .lane_act    (lane_act),
    .drive_en    (drive_en),
    .rsp_valid   (rsp_valid)
  );

  sram_lane_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept_rd || ev_accept_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (ev_capture),
    .drive_en  (drive_en),
    .lane_act  (lane_act),
    .ram_dq_in (ram_dq_in),
    .ram_addr  (ram_addr),
    .ram_dq_out(ram_dq_out),
    .ram_dq_oe (ram_dq_oe),
    .rsp_data  (rsp_data)
  );

  assign ram_lb_n = !lane_act[0];
  assign ram_ub_n = !lane_act[1];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ev_noop,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_ce_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_ub_n,
  input logic              ram_lb_n,
  input logic [1:0]        ram_dq_oe
);

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_oe_n && ram_we_n && ram_dq_oe == 2'b00));

  p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_write_gate_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (ram_oe_n && !ram_ce_n && !(ram_ub_n && ram_lb_n)));

  p_drive_own_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe[0] |-> !ram_lb_n) and (ram_dq_oe[1] |-> !ram_ub_n));

  p_no_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_dq_oe) |-> ram_oe_n);

  p_drive_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |=> (ram_dq_oe == 2'b00));

  p_read_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_noop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_noop |=> (ram_we_n && ram_ce_n && req_ready));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> ($stable(ram_addr) && $stable(ram_ub_n) && $stable(ram_lb_n)));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ev_noop  (ev_noop),
  .ram_addr (ram_addr),
  .ram_ce_n (ram_ce_n),
  .ram_oe_n (ram_oe_n),
  .ram_we_n (ram_we_n),
  .ram_ub_n (ram_ub_n),
  .ram_lb_n (ram_lb_n),
  .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int GRADE  = 55;
  localparam int AW     = 17;
  // Fastest-grade figures (R10), restated independently.
  localparam int T_AA = 55, T_HZOE = 20, T_HZWE = 30, T_PWE = 45;
  localparam int T_AW = 50, T_SD = 25, T_WC = 55;
  localparam int C_RD   = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int C_HZOE = (T_HZOE + CLK_NS - 1) / CLK_NS;
  localparam int C_HZWE = (T_HZWE + CLK_NS - 1) / CLK_NS;
  localparam int C_SD   = (T_SD + CLK_NS - 1) / CLK_NS;
  localparam int C_PWE  = (T_PWE + CLK_NS - 1) / CLK_NS;
  localparam int C_AW   = (T_AW + CLK_NS - 1) / CLK_NS;
  localparam int C_WC   = (T_WC + CLK_NS - 1) / CLK_NS;
  localparam int C_WL0  = (C_PWE > C_AW) ? C_PWE : C_AW;
  localparam int C_WL   = (C_WL0 > C_HZWE + C_SD) ? C_WL0 : C_HZWE + C_SD;
  localparam int C_WBSY = (C_WL + 1 > C_WC) ? C_WL + 1 : C_WC;
  localparam int C_RBSY = C_RD + C_HZOE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_valid, ram_ce_n, ram_oe_n, ram_we_n, ram_ub_n, ram_lb_n;
  logic [15:0] rsp_data, ram_dq_out, ram_dq_in;
  logic [AW-1:0] ram_addr;
  logic [1:0] ram_dq_oe;

  sram_lane_ctrl #(.ADDR_W(AW), .CLK_NS(CLK_NS), .SPEED_NS(GRADE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_ub_n(ram_ub_n), .ram_lb_n(ram_lb_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in));

  always #(CLK_NS / 2) clk = ~clk;

  int errors = 0, checks = 0, pc = 0, we_falls = 0;
  logic [15:0] ram_mem [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  int acc_q [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(ref logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  always @(posedge clk) pc <= pc + 1;

  // Pin-level RAM model with timing checks.
  logic p_act = 0, p_we_n = 1, p_oe_n = 1, pend_off = 0;
  logic [1:0] p_lanes = 0;
  logic [15:0] p_dq = 0;
  int p_addr = 0, we_low = 0, rd_n = 0, since_we_fall = 99, since_oe_rise = 99;
  int drv_n [2] = '{0, 0};
  initial ram_dq_in = 16'hEEEE;

  always @(negedge clk) begin
    logic act, drives;
    logic [15:0] word, v;
    if (rst_n) begin
      if (p_we_n && !ram_we_n) begin since_we_fall = 1; we_falls++; end
      else if (!ram_we_n) since_we_fall++;
      if (!p_oe_n && ram_oe_n) since_oe_rise = 1;
      else if (ram_oe_n && since_oe_rise < 99) since_oe_rise++;
      if (pend_off) begin
        check(ram_dq_oe == 2'b00, "R5", "drive off one cycle after strobe rise", ram_dq_oe, 0);
        pend_off = 0;
      end
      if (|ram_dq_oe) begin
        check(ram_oe_n, "R5", "drive while output gate low", ram_oe_n, 1);
        check((since_oe_rise - 1) * CLK_NS >= T_HZOE, "R5", "drive before gate float", since_oe_rise - 1, C_HZOE);
        if (!ram_we_n)
          check((since_we_fall - 1) * CLK_NS >= T_HZWE, "R5", "drive before strobe float", since_we_fall - 1, C_HZWE);
      end
      act = !ram_ce_n && !ram_we_n && (!ram_ub_n || !ram_lb_n);
      if (act) begin
        we_low++;
        for (int l = 0; l < 2; l++) drv_n[l] = ram_dq_oe[l] ? drv_n[l] + 1 : 0;
        p_dq = ram_dq_out; p_addr = int'(ram_addr); p_lanes = {!ram_ub_n, !ram_lb_n};
      end else if (p_act) begin
        check(we_low == C_WL, "R4", "write strobe width", we_low, C_WL);
        word = rd(ram_mem, p_addr);
        for (int l = 0; l < 2; l++) if (p_lanes[l]) begin
          check(drv_n[l] * CLK_NS >= T_SD, "R5", "data setup", drv_n[l], C_SD);
          word[l*8 +: 8] = p_dq[l*8 +: 8];
        end
        ram_mem[p_addr] = word;
        we_low = 0; drv_n[0] = 0; drv_n[1] = 0; pend_off = 1;
      end
      p_act = act;
      drives = !ram_ce_n && !ram_oe_n && ram_we_n;
      rd_n = drives ? rd_n + 1 : 0;
      if (drives) begin
        word = rd(ram_mem, int'(ram_addr));
        v = (rd_n * CLK_NS >= T_AA) ? word : 16'hC3C3;
        if (ram_lb_n) v[7:0] = 8'h3C;
        if (ram_ub_n) v[15:8] = 8'h3C;
        ram_dq_in = v;
      end else ram_dq_in = 16'hEEEE;
    end
    p_we_n = ram_we_n; p_oe_n = ram_oe_n;
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check(0, "R2", "unexpected response", rsp_data, 0);
      else begin
        logic [15:0] e;
        int a;
        e = exp_q.pop_front(); a = acc_q.pop_front();
        check(rsp_data == e, "R2/R3", "read data", rsp_data, e);
        check(pc - a == C_RD, "R2", "read latency", pc - a, C_RD);
      end
    end
  end

  task automatic op(input bit w, input int a, input logic [15:0] d, input logic [1:0] m);
    int busy, wf;
    logic [15:0] s;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_wdata = d; req_mask = m;
    s = rd(shadow, a);
    if (w) begin
      for (int l = 0; l < 2; l++) if (m[l]) s[l*8 +: 8] = d[l*8 +: 8];
      shadow[a] = s;
    end else begin
      exp_q.push_back(s & {{8{m[1]}}, {8{m[0]}}});
      acc_q.push_back(pc + 1);
    end
    wf = we_falls;
    @(negedge clk);
    req_valid = 0;
    if (w && m == 2'b00) begin
      for (int i = 0; i < 3; i++) begin
        check(req_ready && ram_ce_n, "R8", "no-op write keeps idle", {req_ready, ram_ce_n}, 3);
        @(negedge clk);
      end
      check(we_falls == wf, "R8", "no-op write strobe", we_falls - wf, 0);
    end else begin
      busy = 0;
      while (!req_ready) begin busy++; @(negedge clk); end
      if (w) check(busy == C_WBSY, "R7", "write busy cycles", busy, C_WBSY);
      else   check(busy == C_RBSY, "R6", "read busy cycles", busy, C_RBSY);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (pc > 20000) begin
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && ram_ce_n && ram_oe_n && ram_we_n && ram_dq_oe == 0 && !rsp_valid,
          "R1", "reset state", {req_ready, ram_ce_n, ram_oe_n, ram_we_n}, 4'hF);
    rst_n = 1;
    @(negedge clk);
    op(1, 16, 16'h1234, 2'b11);
    op(0, 16, 16'h0, 2'b11);
    op(1, 16, 16'hAB99, 2'b01);          // R4 low lane only
    op(0, 16, 16'h0, 2'b11);
    op(1, 'h1FFFF, 16'hCD77, 2'b10);     // R4 high lane only
    op(0, 'h1FFFF, 16'h0, 2'b11);
    op(0, 16, 16'h0, 2'b01);             // R3 low lane read
    op(0, 16, 16'h0, 2'b10);             // R3 high lane read
    op(1, 16, 16'hFFFF, 2'b00);          // R8 no-op
    op(0, 16, 16'h0, 2'b11);
    op(1, 0, 16'hA5C3, 2'b11);
    op(1, 1, 16'h5A3C, 2'b11);
    op(0, 0, 16'h0, 2'b11);
    op(0, 1, 16'h0, 2'b11);
    op(0, 0, 16'h0, 2'b00);              // R3 both lanes dark
    op(1, 'h0AAAA, 16'h0F0F, 2'b11);
    op(0, 'h0AAAA, 16'h0, 2'b11);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
    check(req_ready && ram_ce_n && ram_we_n && ram_oe_n && ram_dq_oe == 0,
          "R1", "idle standby", {req_ready, ram_ce_n, ram_oe_n, ram_we_n}, 4'hF);
    summary();
  end
endmodule